// File: doc/BRIEF.md
# Armed Cursor Register Update Latch

This block sits between a register write port and a cursor scanout engine. Software programs four cursor registers: control, position, surface base and size-control. Every write lands in a pending copy. The active copies that scanout reads change only at a vertical-blank strobe, and only when an update has been armed. All four active registers move together in one clock cycle, so scanout never sees a mix of old and new settings.

An update is armed by certain writes. A write to the base register arms it. A control write that turns a disabled cursor on arms it. A position write arms it only if no control write has happened since the last base write. Any other cursor write cancels an armed update that has not yet been taken. The block also decodes the active size setting into the cursor height and reports whether the cursor is shown.

Top module: `cursor_upd_latch`

## Requirements
- R1: During and after reset, all four active copies are zero, `upd_pending` is 0, `cursor_on` is 0 and `height_m1` is 0.
- R2: A write changes only the pending copy addressed by `wr_addr` (0 control, 1 position, 2 base, 3 size-control). The active outputs do not change until an armed vblank occurs.
- R3: A base write (address 2) arms the update. On the next `vblank` strobe, all four active copies take their pending values in the same cycle and `upd_pending` returns to 0.
- R4: A write that does not arm, made while an update is armed, cancels it. A later `vblank` then transfers nothing.
- R5: A control write whose mode field (bits 1:0) is non-zero arms the update when the active control mode is zero, meaning the cursor is being turned on.
- R6: A position write arms the update only when no control write has occurred since the most recent base write. Otherwise it acts as a cancelling write, and a following base write arms.
- R7: The size-control register enables a non-square height with bit 31 and holds height-1 in bits 7:0. When bit 31 is set, `height_m1` equals that field. When it is clear, `height_m1` is the square size for the mode: 63, 127 or 255 for modes 1, 2 and 3, and 0 for mode 0.
- R8: `cursor_on` is 1 exactly when the active control mode field is non-zero.
- R9: When a write and an armed `vblank` fall in the same cycle, the transfer uses the pending values from before that write. The write is then stored, and `upd_pending` afterwards reflects only whether that write arms.
- R10: A `vblank` with no armed update leaves every active output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 position, 2 base, 3 size-control |
| wr_data | input | 32 | Write data |
| vblank | input | 1 | Vertical-blank strobe, one cycle |
| act_ctl | output | 32 | Active control register |
| act_pos | output | 32 | Active position register |
| act_base | output | 32 | Active base register |
| act_size | output | 32 | Active size-control register |
| height_m1 | output | 8 | Active cursor height minus one |
| cursor_on | output | 1 | Active mode field non-zero |
| upd_pending | output | 1 | An armed update is waiting for vblank |

## Verification
If the armed flag is wrong, the error shows on `upd_pending` in the cycle after the write. It also shows at the next vblank, when the active base either moves when it should stay or stays when it should move. If the record of an earlier control write is wrong, only a position write reveals it, by arming or failing to arm one cycle later. A transfer that splits the registers, or that copies the pending values from after a same-cycle write, shows one cycle after the vblank as an active register that does not match the other three. The bench runs a sequence that reaches each of these cases and checks the outputs one cycle after every step.

// File: rtl/cur_pkg.sv
// Package: shared register indices and field geometry for the cursor latch.
// Assumes four cursor registers addressed by a 2-bit select.
package cur_pkg;
    localparam int NREG   = 4;
    localparam int MODE_W = 2;

    typedef enum logic [1:0] {
        REG_CTL  = 2'd0,
        REG_POS  = 2'd1,
        REG_BASE = 2'd2,
        REG_SIZE = 2'd3
    } creg_e;
endpackage

// File: rtl/cur_arm_ctrl.sv
// Arming control: keeps the armed flag and a record of a control write seen
// since the last base write; decides the transfer strobe.
// Assumes one write per cycle; act_on_ref is the enable state that will be
// active after this cycle's transfer.
module cur_arm_ctrl
    import cur_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_en,
    input  creg_e wr_sel,
    input  logic  wr_mode_on,
    input  logic  act_on_ref,
    input  logic  vblank,
    output logic  armed,
    output logic  xfer
);
    logic ctl_seen;
    logic arm_hit;
    logic armed_nxt;

    assign xfer = vblank & armed;

    // Decide whether the current write arms the update.
    always_comb begin
        unique case (wr_sel)
            REG_BASE: arm_hit = 1'b1;
            REG_CTL:  arm_hit = wr_mode_on & ~act_on_ref;
            REG_POS:  arm_hit = ~ctl_seen;
            default:  arm_hit = 1'b0;
        endcase
    end

    // Next armed value: a write decides it outright; otherwise a transfer clears it.
    always_comb begin
        if (wr_en)
            armed_nxt = arm_hit;
        else if (xfer)
            armed_nxt = 1'b0;
        else
            armed_nxt = armed;
    end

    // Armed flag register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed <= 1'b0;
        else
            armed <= armed_nxt;
    end

    // Remember a control write until the next base write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctl_seen <= 1'b0;
        else if (wr_en && wr_sel == REG_CTL)
            ctl_seen <= 1'b1;
        else if (wr_en && wr_sel == REG_BASE)
            ctl_seen <= 1'b0;
    end

    p_base_arms_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == REG_BASE) |=> armed);

    p_size_cancels_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == REG_SIZE) |=> !armed);

    p_xfer_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && !wr_en) |=> !armed);

    p_pos_after_ctl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == REG_POS && ctl_seen) |=> !armed);

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !armed) |=> !armed);
endmodule

// File: rtl/cur_reg_bank.sv
// Register bank: one pending and one active copy per cursor register.
// Assumes xfer copies all pending values in one cycle, using the values held
// before any write in that same cycle.
module cur_reg_bank #(
    parameter int DW   = 32,
    parameter int NR   = 4,
    localparam int AW  = $clog2(NR)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [AW-1:0]          wr_idx,
    input  logic [DW-1:0]          wr_data,
    input  logic                   xfer,
    output logic [NR-1:0][DW-1:0]  pend,
    output logic [NR-1:0][DW-1:0]  act
);
    for (genvar i = 0; i < NR; i++) begin : g_reg
        // Pending copy: takes the write addressed to it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                pend[i] <= '0;
            else if (wr_en && wr_idx == AW'(i))
                pend[i] <= wr_data;
        end

        // Active copy: loads the pending value on a transfer.
        always_ff @(posedge clk) begin
            if (!rst_n)
                act[i] <= '0;
            else if (xfer)
                act[i] <= pend[i];
        end

        p_act_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
            !xfer |=> $stable(act[i]));

        p_xfer_copy_r3: assert property (@(posedge clk) disable iff (!rst_n)
            xfer |=> act[i] == $past(pend[i]));
    end
endmodule

// File: rtl/cur_shape.sv
// Shape decode: derives the active cursor height and the visible flag from
// the active control mode and size-control register.
// Assumes mode 1/2/3 select square sizes 64/128/256 and mode 0 means off.
module cur_shape
    import cur_pkg::*;
#(
    parameter int DW     = 32,
    parameter int HGT_W  = 8,
    parameter int SZ_EN  = 31
) (
    input  logic [MODE_W-1:0] mode,
    input  logic [DW-1:0]     size_reg,
    output logic [HGT_W-1:0]  height_m1,
    output logic              on
);
    logic [HGT_W-1:0] sq_m1;

    assign on = (mode != '0);

    // Square height for each mode.
    always_comb begin
        unique case (mode)
            2'd1:    sq_m1 = HGT_W'(63);
            2'd2:    sq_m1 = HGT_W'(127);
            2'd3:    sq_m1 = HGT_W'(255);
            default: sq_m1 = '0;
        endcase
    end

    // Non-square override from size-control.
    always_comb begin
        if (size_reg[SZ_EN])
            height_m1 = size_reg[HGT_W-1:0];
        else
            height_m1 = sq_m1;
    end
endmodule

// File: rtl/cursor_upd_latch.sv
// Top: cursor register interface with armed, vblank-synchronous transfer of
// pending register values into the active set used by scanout.
// Assumes single-cycle write strobes and a one-cycle vblank strobe.
module cursor_upd_latch
    import cur_pkg::*;
#(
    parameter int DW    = 32,
    parameter int HGT_W = 8,
    parameter int SZ_EN = 31,
    localparam int AW   = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic              vblank,
    output logic [DW-1:0]     act_ctl,
    output logic [DW-1:0]     act_pos,
    output logic [DW-1:0]     act_base,
    output logic [DW-1:0]     act_size,
    output logic [HGT_W-1:0]  height_m1,
    output logic              cursor_on,
    output logic              upd_pending
);
    logic [NREG-1:0][DW-1:0] pend;
    logic [NREG-1:0][DW-1:0] act;
    logic                    xfer;
    logic                    act_on_ref;
    logic                    wr_mode_on;

    assign wr_mode_on = (wr_data[MODE_W-1:0] != '0);
    // Enable state that is active once this cycle's transfer (if any) lands.
    assign act_on_ref = xfer ? (pend[REG_CTL][MODE_W-1:0] != '0)
                             : (act[REG_CTL][MODE_W-1:0] != '0);

    cur_arm_ctrl u_arm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (creg_e'(wr_addr)),
        .wr_mode_on (wr_mode_on),
        .act_on_ref (act_on_ref),
        .vblank     (vblank),
        .armed      (upd_pending),
        .xfer       (xfer)
    );

    cur_reg_bank #(.DW(DW), .NR(NREG)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_addr),
        .wr_data (wr_data),
        .xfer    (xfer),
        .pend    (pend),
        .act     (act)
    );

    assign act_ctl  = act[REG_CTL];
    assign act_pos  = act[REG_POS];
    assign act_base = act[REG_BASE];
    assign act_size = act[REG_SIZE];

    cur_shape #(.DW(DW), .HGT_W(HGT_W), .SZ_EN(SZ_EN)) u_shape (
        .mode      (act_ctl[MODE_W-1:0]),
        .size_reg  (act_size),
        .height_m1 (height_m1),
        .on        (cursor_on)
    );

    p_enable_arms_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == AW'(REG_CTL) && wr_mode_on && !act_on_ref)
        |=> upd_pending);

    p_on_follows_ctl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !vblank |=> $stable(cursor_on));
endmodule

// File: tb/sim_cursor_upd_latch.sv
module sim_cursor_upd_latch;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [1:0]  wr_addr;
    logic [31:0] wr_data;
    logic        vblank;
    logic [31:0] act_ctl, act_pos, act_base, act_size;
    logic [7:0]  height_m1;
    logic        cursor_on, upd_pending;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    cursor_upd_latch u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .vblank(vblank), .act_ctl(act_ctl),
        .act_pos(act_pos), .act_base(act_base), .act_size(act_size),
        .height_m1(height_m1), .cursor_on(cursor_on),
        .upd_pending(upd_pending)
    );

    typedef struct packed {
        logic        wr;
        logic [1:0]  a;
        logic [31:0] d;
        logic        vb;
        logic        e_arm;
        logic        e_on;
        logic [31:0] e_base;
        logic [7:0]  e_h;
    } vec_t;

    // Walk from reset; comments give the requirement exercised by each row.
    localparam vec_t TBL [20] = '{
        '{1'b1, 2'd2, 32'h1000,     1'b0, 1'b1, 1'b0, 32'h0,    8'd0},   // R3 base arms
        '{1'b0, 2'd0, 32'h0,        1'b1, 1'b0, 1'b0, 32'h1000, 8'd0},   // R3 transfer
        '{1'b1, 2'd0, 32'h2,        1'b0, 1'b1, 1'b0, 32'h1000, 8'd0},   // R5 enable arms
        '{1'b1, 2'd1, 32'h00100020, 1'b0, 1'b0, 1'b0, 32'h1000, 8'd0},   // R6/R4 pos cancels
        '{1'b0, 2'd0, 32'h0,        1'b1, 1'b0, 1'b0, 32'h1000, 8'd0},   // R4/R10 no transfer
        '{1'b1, 2'd2, 32'h2000,     1'b0, 1'b1, 1'b0, 32'h1000, 8'd0},   // R6 base arms
        '{1'b0, 2'd0, 32'h0,        1'b1, 1'b0, 1'b1, 32'h2000, 8'd127}, // R7/R8 square 128
        '{1'b1, 2'd1, 32'h5,        1'b0, 1'b1, 1'b1, 32'h2000, 8'd127}, // R6 pos self-arms
        '{1'b1, 2'd3, 32'h80000010, 1'b0, 1'b0, 1'b1, 32'h2000, 8'd127}, // R4 size cancels
        '{1'b1, 2'd1, 32'h6,        1'b0, 1'b1, 1'b1, 32'h2000, 8'd127}, // R6 pos re-arms
        '{1'b0, 2'd0, 32'h0,        1'b1, 1'b0, 1'b1, 32'h2000, 8'd16},  // R7 non-square
        '{1'b1, 2'd0, 32'h3,        1'b0, 1'b0, 1'b1, 32'h2000, 8'd16},  // R5 no arm when on
        '{1'b1, 2'd2, 32'h3000,     1'b0, 1'b1, 1'b1, 32'h2000, 8'd16},  // R3 base arms
        '{1'b1, 2'd3, 32'h0,        1'b1, 1'b0, 1'b1, 32'h3000, 8'd16},  // R9 old size moved
        '{1'b1, 2'd2, 32'h3000,     1'b0, 1'b1, 1'b1, 32'h3000, 8'd16},  // R3
        '{1'b0, 2'd0, 32'h0,        1'b1, 1'b0, 1'b1, 32'h3000, 8'd255}, // R7 square 256
        '{1'b1, 2'd0, 32'h0,        1'b0, 1'b0, 1'b1, 32'h3000, 8'd255}, // R2 disable pending
        '{1'b1, 2'd2, 32'h4000,     1'b0, 1'b1, 1'b1, 32'h3000, 8'd255}, // R3
        '{1'b1, 2'd2, 32'h5000,     1'b1, 1'b1, 1'b0, 32'h4000, 8'd0},  // R9 re-armed
        '{1'b0, 2'd0, 32'h0,        1'b1, 1'b0, 1'b0, 32'h5000, 8'd0}    // R9 second transfer
    };

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, got, exp);
        end
    endtask

    // Apply one cycle of stimulus from a falling edge; return at the next falling edge.
    task automatic step(input logic w, input logic [1:0] a, input logic [31:0] d, input logic v);
        wr_en = w; wr_addr = a; wr_data = d; vblank = v;
        @(negedge clk);
        wr_en = 1'b0; vblank = 1'b0;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = 2'd0; wr_data = '0; vblank = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 ctl",  act_ctl, 0);
        chk("R1 base", act_base, 0);
        chk("R1 pend", 32'(upd_pending), 0);
        chk("R1 on",   32'(cursor_on), 0);
        chk("R1 h",    32'(height_m1), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < 20; i++) begin
            step(TBL[i].wr, TBL[i].a, TBL[i].d, TBL[i].vb);
            chk($sformatf("row%0d armed", i), 32'(upd_pending), 32'(TBL[i].e_arm));
            chk($sformatf("row%0d R8 on", i), 32'(cursor_on), 32'(TBL[i].e_on));
            chk($sformatf("row%0d base", i), act_base, TBL[i].e_base);
            chk($sformatf("row%0d R7 h", i), 32'(height_m1), 32'(TBL[i].e_h));
        end
        chk("R6 pos from table", act_pos, 32'h6);

        // Enable from off arms; active unchanged (R5, R2).
        step(1'b1, 2'd0, 32'h1, 1'b0);
        chk("R5 armed", 32'(upd_pending), 1);
        chk("R2 ctl held", act_ctl, 0);
        step(1'b1, 2'd3, 32'h80000020, 1'b0);
        chk("R4 size cancels", 32'(upd_pending), 0);
        step(1'b1, 2'd1, 32'h77, 1'b0);
        chk("R6 pos after ctl", 32'(upd_pending), 0);
        chk("R2 pos held", act_pos, 32'h6);
        step(1'b1, 2'd2, 32'h6000, 1'b0);
        chk("R3 armed", 32'(upd_pending), 1);
        step(1'b0, 2'd0, 32'h0, 1'b1);
        chk("R3 ctl",  act_ctl, 32'h1);
        chk("R3 pos",  act_pos, 32'h77);
        chk("R3 base", act_base, 32'h6000);
        chk("R3 size", act_size, 32'h80000020);
        chk("R7 h",    32'(height_m1), 32'h20);
        chk("R3 clear", 32'(upd_pending), 0);

        // Unarmed vblank changes nothing (R10).
        step(1'b1, 2'd0, 32'h2, 1'b0);
        chk("R10 not armed", 32'(upd_pending), 0);
        step(1'b0, 2'd0, 32'h0, 1'b1);
        chk("R10 ctl held", act_ctl, 32'h1);

        // Reset mid-run clears active state (R1).
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 ctl again", act_ctl, 0);
        chk("R1 pos again", act_pos, 0);
        chk("R1 size again", act_size, 0);
        rst_n = 1'b1;

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule